// File: doc/BRIEF.md
# PCI Command and Status Register Unit

This block holds the 16-bit command register and the 16-bit status register of a host-to-PCI bridge. Both share one configuration dword. The command register sits in the low half and the status register in the high half. A configuration port reaches them with a dword index, byte enables, a write strobe and 32-bit data.

Status bits are set by single-cycle event pulses from the PCI side. Software can only clear them, by writing ones. A status write counts only when it is a halfword access to the upper half of the dword.

The command register drives three control outputs: target memory-space decode enable, bus-master enable and parity-error response. The bus-master bit also gates outbound host-to-PCI requests, which arrive on a valid/ready handshake. While mastering is off, writes are accepted and discarded at once. Reads are accepted at once and flagged with an error, but only when the external error-enable input is high.

Top module: `pcicr_top`

## Requirements
- R1: After a synchronous active-high reset, the command register reads 0x0006 and the status register reads 0x0000, so `mem_decode_en` and `bus_master_en` are 1.
- R2: Software can never set a status bit. A pulse on `sts_event[i]` sets status bit i only if bit i is implemented. The implemented bits are 15, 14, 13, 12, 11 and 8 (mask 0xF900). All other status bits read 0.
- R3: A write to dword index 1 with `cfg_be` exactly 4'b1100 clears every status bit whose position holds a 1 in `cfg_wdata[31:16]`. Status bits written with 0 keep their value. For example, 0x4000 in the upper half clears only bit 14.
- R4: A write to dword index 1 with any other byte-enable pattern, including 4'b1111 and 4'b1000, leaves the status register unchanged.
- R5: When an event pulse and a clearing write hit the same status bit in the same cycle, the bit ends up set.
- R6: `cfg_rdata` is {status, command} while `cfg_addr` is 1 and zero for any other index. Reading changes no state.
- R7: A write to dword index 1 with `cfg_be[0]` set loads command bits 1 (memory space), 2 (bus master) and 6 (parity response) from `cfg_wdata`. Command bits 0, 3, 4, 5 and 7 to 15 always read 0.
- R8: `mem_decode_en` follows command bit 1, and `bus_master_en` follows command bit 2.
- R9: `perr_resp` is high in a cycle exactly when `perr_event` is high and command bit 6 is 1.
- R10: With bus master on, an outbound request passes through unchanged: `fwd_valid` equals `ob_valid`, `ob_ready` equals `fwd_ready`, and `ob_err` is 0.
- R11: With bus master off, an outbound write (`ob_write`=1) sees `ob_ready`=1 in the same cycle. It is not forwarded and gets no error.
- R12: With bus master off, an outbound read sees `ob_ready`=1 in the same cycle and is not forwarded. `ob_err` equals `err_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_valid | input | 1 | Configuration access strobe |
| cfg_we | input | 1 | 1 = write, 0 = read |
| cfg_addr | input | 6 | Configuration dword index |
| cfg_be | input | 4 | Byte enables of the dword |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data, combinational |
| sts_event | input | 16 | Status set pulses, one per bit |
| perr_event | input | 1 | Parity error detected |
| perr_resp | output | 1 | Parity error response to error handling |
| mem_decode_en | output | 1 | Target memory-space decode enable |
| bus_master_en | output | 1 | Bus-master enable |
| ob_valid | input | 1 | Outbound request valid |
| ob_write | input | 1 | Outbound request is a write |
| ob_ready | output | 1 | Outbound request accepted |
| ob_err | output | 1 | Outbound read terminated with error |
| fwd_valid | output | 1 | Request forwarded to PCI engine |
| fwd_ready | input | 1 | PCI engine accepts request |
| err_en | input | 1 | Error-response enable for dropped reads |

## Verification
The hardest case to reach is a clearing write and an event pulse landing on the same status bit in the same cycle. Only a cycle-exact alignment of the configuration write with the event input produces it. The vector table drives both in one row, together with a clear of a different bit, and then reads the dword back. That read shows the contended bit kept and the other bit cleared. Halfword checking is exercised by rows that use the full-dword enable and the upper-byte-only enable with all-ones data, which must leave the status untouched.

// File: rtl/pcicr_pkg.sv
package pcicr_pkg;
   localparam int unsigned REG_W = 16;
   localparam int unsigned CFG_W = 2 * REG_W;
   localparam int unsigned BE_W  = CFG_W / 8;

   // command bits with real storage
   localparam int unsigned CMD_MEM_BIT  = 1;
   localparam int unsigned CMD_MST_BIT  = 2;
   localparam int unsigned CMD_PERR_BIT = 6;
   localparam logic [7:0]  CMD_WR_MASK  = 8'h46;
   localparam logic [7:0]  CMD_RST_VAL  = 8'h06;

   // only a halfword aimed at the upper half reaches the status register
   localparam logic [BE_W-1:0] STS_BE = 4'b1100;

   typedef enum logic [1:0] {
      OB_PASS = 2'd0,
      OB_DROP = 2'd1,
      OB_FAIL = 2'd2
   } ob_mode_e;
endpackage

// File: rtl/pcicr_cmd_reg.sv
module pcicr_cmd_reg
   import pcicr_pkg::*;
(
   input  logic             clk,
   input  logic             rst,
   input  logic             wr_en,
   input  logic [7:0]       wr_byte,
   output logic [REG_W-1:0] cmd_q,
   output logic             mem_en,
   output logic             mst_en,
   output logic             perr_en
);
   logic [7:0] cmd_lo;

   always_ff @(posedge clk) begin
      if (rst)        cmd_lo <= CMD_RST_VAL;
      else if (wr_en) cmd_lo <= wr_byte & CMD_WR_MASK;
   end

   assign cmd_q   = {{(REG_W-8){1'b0}}, cmd_lo};
   assign mem_en  = cmd_lo[CMD_MEM_BIT];
   assign mst_en  = cmd_lo[CMD_MST_BIT];
   assign perr_en = cmd_lo[CMD_PERR_BIT];

   AST_CMD_HOLD: assert property (@(posedge clk) disable iff (rst)
      !wr_en |=> $stable(cmd_lo)); // R7
endmodule

// File: rtl/pcicr_sts_reg.sv
module pcicr_sts_reg
   import pcicr_pkg::*;
#(
   parameter logic [REG_W-1:0] IMPL_MASK = 16'hF900
)(
   input  logic             clk,
   input  logic             rst,
   input  logic             clr_en,
   input  logic [REG_W-1:0] clr_bits,
   input  logic [REG_W-1:0] set_bits,
   output logic [REG_W-1:0] sts_q
);
   for (genvar i = 0; i < REG_W; i++) begin : g_bit
      if (IMPL_MASK[i]) begin : g_impl
         always_ff @(posedge clk) begin
            if (rst)                    sts_q[i] <= 1'b0;
            else if (set_bits[i])       sts_q[i] <= 1'b1;
            else if (clr_en && clr_bits[i]) sts_q[i] <= 1'b0;
         end

         AST_STS_NO_SW_SET: assert property (@(posedge clk) disable iff (rst)
            (!set_bits[i] && !sts_q[i]) |=> !sts_q[i]); // R2
         AST_STS_SET_WINS: assert property (@(posedge clk) disable iff (rst)
            set_bits[i] |=> sts_q[i]); // R5
         AST_STS_W1C: assert property (@(posedge clk) disable iff (rst)
            (clr_en && clr_bits[i] && !set_bits[i]) |=> !sts_q[i]); // R3
      end else begin : g_zero
         assign sts_q[i] = 1'b0;
      end
   end
endmodule

// File: rtl/pcicr_ob_gate.sv
module pcicr_ob_gate
   import pcicr_pkg::*;
(
   input  logic clk,
   input  logic rst,
   input  logic mst_en,
   input  logic err_en,
   input  logic ob_valid,
   input  logic ob_write,
   output logic ob_ready,
   output logic ob_err,
   output logic fwd_valid,
   input  logic fwd_ready
);
   ob_mode_e mode;

   always_comb begin
      if (mst_en)        mode = OB_PASS;
      else if (ob_write) mode = OB_DROP;
      else               mode = OB_FAIL;
   end

   always_comb begin
      fwd_valid = 1'b0;
      ob_ready  = 1'b1;
      ob_err    = 1'b0;
      unique case (mode)
         OB_PASS: begin
            fwd_valid = ob_valid;
            ob_ready  = fwd_ready;
         end
         OB_DROP: ;
         OB_FAIL: ob_err = ob_valid & err_en;
         default: ;
      endcase
   end

   AST_DROP_NO_FWD: assert property (@(posedge clk) disable iff (rst)
      (!mst_en && ob_valid) |-> (ob_ready && !fwd_valid)); // R11
   AST_WR_NO_ERR: assert property (@(posedge clk) disable iff (rst)
      (ob_valid && ob_write) |-> !ob_err); // R11
   AST_PASS_NO_ERR: assert property (@(posedge clk) disable iff (rst)
      mst_en |-> !ob_err); // R10
endmodule

// File: rtl/pcicr_top.sv
module pcicr_top
   import pcicr_pkg::*;
#(
   parameter int unsigned      ADDR_W   = 6,
   parameter int unsigned      CS_DWORD = 1,
   parameter logic [REG_W-1:0] STS_IMPL = 16'hF900
)(
   input  logic              clk,
   input  logic              rst,
   input  logic              cfg_valid,
   input  logic              cfg_we,
   input  logic [ADDR_W-1:0] cfg_addr,
   input  logic [BE_W-1:0]   cfg_be,
   input  logic [CFG_W-1:0]  cfg_wdata,
   output logic [CFG_W-1:0]  cfg_rdata,
   input  logic [REG_W-1:0]  sts_event,
   input  logic              perr_event,
   output logic              perr_resp,
   output logic              mem_decode_en,
   output logic              bus_master_en,
   input  logic              ob_valid,
   input  logic              ob_write,
   output logic              ob_ready,
   output logic              ob_err,
   output logic              fwd_valid,
   input  logic              fwd_ready,
   input  logic              err_en
);
   if (CS_DWORD >= (1 << ADDR_W)) begin : g_bad_addr
      $error("CS_DWORD does not fit in ADDR_W");
   end
   if (ADDR_W < 1 || ADDR_W > 16) begin : g_bad_aw
      $error("ADDR_W out of range");
   end

   logic              hit, wr_hit, cmd_wr, sts_wr, perr_en;
   logic [REG_W-1:0]  cmd_q, sts_q;

   assign hit    = (cfg_addr == ADDR_W'(CS_DWORD));
   assign wr_hit = cfg_valid && cfg_we && hit;
   assign cmd_wr = wr_hit && cfg_be[0];
   assign sts_wr = wr_hit && (cfg_be == STS_BE);

   pcicr_cmd_reg u_cmd (
      .clk     (clk),
      .rst     (rst),
      .wr_en   (cmd_wr),
      .wr_byte (cfg_wdata[7:0]),
      .cmd_q   (cmd_q),
      .mem_en  (mem_decode_en),
      .mst_en  (bus_master_en),
      .perr_en (perr_en)
   );

   pcicr_sts_reg #(.IMPL_MASK(STS_IMPL)) u_sts (
      .clk      (clk),
      .rst      (rst),
      .clr_en   (sts_wr),
      .clr_bits (cfg_wdata[CFG_W-1:REG_W]),
      .set_bits (sts_event),
      .sts_q    (sts_q)
   );

   pcicr_ob_gate u_ob (
      .clk       (clk),
      .rst       (rst),
      .mst_en    (bus_master_en),
      .err_en    (err_en),
      .ob_valid  (ob_valid),
      .ob_write  (ob_write),
      .ob_ready  (ob_ready),
      .ob_err    (ob_err),
      .fwd_valid (fwd_valid),
      .fwd_ready (fwd_ready)
   );

   assign cfg_rdata = hit ? {sts_q, cmd_q} : '0;
   assign perr_resp = perr_event & perr_en;

   AST_STS_SIZE_GUARD: assert property (@(posedge clk) disable iff (rst)
      (wr_hit && cfg_be != STS_BE && sts_event == '0) |=> $stable(sts_q)); // R4
   AST_READ_NO_EFFECT: assert property (@(posedge clk) disable iff (rst)
      (!(cfg_valid && cfg_we) && sts_event == '0) |=> $stable({sts_q, cmd_q})); // R6
endmodule

// File: tb/pcicr_top_test.sv
`timescale 1ns/1ps
module pcicr_top_test;
   logic        clk = 1'b0;
   logic        rst;
   logic        cfg_valid, cfg_we;
   logic [5:0]  cfg_addr;
   logic [3:0]  cfg_be;
   logic [31:0] cfg_wdata, cfg_rdata;
   logic [15:0] sts_event;
   logic        perr_event, perr_resp, mem_decode_en, bus_master_en;
   logic        ob_valid, ob_write, ob_ready, ob_err, fwd_valid, fwd_ready, err_en;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #2 clk = ~clk;

   pcicr_top uut (.*);

   typedef struct packed {
      logic        we;
      logic [3:0]  be;
      logic [31:0] wd;
      logic [15:0] ev;
      logic [31:0] exp;
   } vec_t;

   // stateful walk from the reset values; dword index 1 throughout
   localparam vec_t VECS [9] = '{
      '{1'b0, 4'h0, 32'h0000_0000, 16'hF900, 32'hF900_0006}, // R2 set all
      '{1'b1, 4'hC, 32'h4000_0000, 16'h0000, 32'hB900_0006}, // R3 clear bit14
      '{1'b1, 4'hF, 32'hFFFF_0000, 16'h0000, 32'hB900_0000}, // R4 dword, R7 cmd 0
      '{1'b1, 4'h8, 32'hFFFF_0000, 16'h0000, 32'hB900_0000}, // R4 single byte
      '{1'b1, 4'h1, 32'h0000_00FF, 16'h0000, 32'hB900_0046}, // R7 only rw bits
      '{1'b0, 4'h0, 32'h0000_0000, 16'h06FF, 32'hB900_0046}, // R2 unimplemented
      '{1'b1, 4'hC, 32'h8100_0000, 16'h0100, 32'h3900_0046}, // R5 set wins
      '{1'b1, 4'h3, 32'hFFFF_FFBF, 16'h0000, 32'h3900_0006}, // R7 upper byte none
      '{1'b1, 4'hC, 32'hFFFF_0000, 16'h0000, 32'h0000_0006}  // R3 clear all
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic idle();
      cfg_valid = 0; cfg_we = 0; cfg_addr = 6'd1; cfg_be = 0; cfg_wdata = 0;
      sts_event = 0; perr_event = 0;
   endtask

   task automatic cfg_wr(input logic [3:0] be, input logic [31:0] wd);
      @(negedge clk);
      cfg_valid = 1; cfg_we = 1; cfg_addr = 6'd1; cfg_be = be; cfg_wdata = wd;
      @(negedge clk);
      idle();
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      idle();
      ob_valid = 0; ob_write = 0; fwd_ready = 0; err_en = 0;
      rst = 1;
      repeat (3) @(negedge clk);
      rst = 0;
      #1;
      chk("R1 reset dword", cfg_rdata, 32'h0000_0006);
      chk("R1 mem_decode_en", {31'd0, mem_decode_en}, 32'd1);
      chk("R1 bus_master_en", {31'd0, bus_master_en}, 32'd1);

      for (int i = 0; i < 9; i++) begin
         @(negedge clk);
         cfg_valid = VECS[i].we; cfg_we = VECS[i].we; cfg_addr = 6'd1;
         cfg_be = VECS[i].be; cfg_wdata = VECS[i].wd; sts_event = VECS[i].ev;
         @(negedge clk);
         idle();
         #1;
         chk($sformatf("vector %0d", i), cfg_rdata, VECS[i].exp);
      end

      // R6: other index reads zero; repeated reads leave state alone
      cfg_addr = 6'd2; #1;
      chk("R6 other index", cfg_rdata, 32'h0);
      cfg_addr = 6'd1; cfg_valid = 1; @(negedge clk); @(negedge clk); cfg_valid = 0; #1;
      chk("R6 read no effect", cfg_rdata, 32'h0000_0006);

      // R9 with command bit6 clear
      perr_event = 1; #1;
      chk("R9 perr ignored", {31'd0, perr_resp}, 32'd0);
      perr_event = 0;

      // R10 pass-through while mastering
      ob_valid = 1; ob_write = 1; fwd_ready = 0; #1;
      chk("R10 stall", {29'd0, ob_ready, fwd_valid, ob_err}, 32'b010);
      fwd_ready = 1; #1;
      chk("R10 accept", {29'd0, ob_ready, fwd_valid, ob_err}, 32'b110);
      ob_write = 0; err_en = 1; #1;
      chk("R10 read no err", {29'd0, ob_ready, fwd_valid, ob_err}, 32'b110);
      ob_valid = 0; fwd_ready = 0; err_en = 0;

      // master off, parity response on
      cfg_wr(4'h1, 32'h0000_0042);
      #1;
      chk("R8 outputs", {30'd0, mem_decode_en, bus_master_en}, 32'b10);
      perr_event = 1; #1;
      chk("R9 perr response", {31'd0, perr_resp}, 32'd1);
      perr_event = 0;
      ob_valid = 1; ob_write = 1; err_en = 1; #1;
      chk("R11 drop write", {29'd0, ob_ready, fwd_valid, ob_err}, 32'b100);
      ob_write = 0; err_en = 0; #1;
      chk("R12 read no err", {29'd0, ob_ready, fwd_valid, ob_err}, 32'b100);
      err_en = 1; #1;
      chk("R12 read err", {29'd0, ob_ready, fwd_valid, ob_err}, 32'b101);
      ob_valid = 0; err_en = 0;

      cfg_wr(4'h1, 32'h0000_0000);
      #1;
      chk("R8 mem decode off", {30'd0, mem_decode_en, bus_master_en}, 32'b00);

      // R1 mid-run reset
      @(negedge clk); sts_event = 16'h0800;
      @(negedge clk); sts_event = 0; rst = 1;
      @(negedge clk); rst = 0; #1;
      chk("R1 mid reset", cfg_rdata, 32'h0000_0006);

      finish_run();
   end
endmodule